// File: doc/BRIEF.md
# Bit-Serial Distributed-Arithmetic FIR Filter

This block is a 32-tap FIR filter that uses no multiplier. Each accepted input sample enters a history of the most recent samples. The block then spends one clock on each bit position of the sample word, least significant bit first. In each of these clocks, one bit is taken from every stored sample. The taps are split into groups of four. Each group's four bits form an address into a small table, and every table entry holds the sum of one subset of that group's coefficients. The table outputs are added together, weighted by the current bit position, and accumulated. With 16-bit samples, a result appears after 16 clocks.

The table contents are written through a word-serial shift chain. New coefficients can therefore be installed at run time, with no change to the logic. While a load is in progress, the filter accepts no samples and produces no results. Normal operation resumes once every table word has been shifted in.

The tables are computed outside the block. For coefficient `c[t]`, table entry `a` of group `g` holds the sum of the `c[g*4+j]` for which bit `j` of `a` is set. Tap 0 is the newest sample.

Top module: `da_fir`

## Requirements
- R1: While reset is applied, and until the first table load completes, `in_ready` and `out_valid` are 0 and `out_data` is 0.
- R2: A table load is a run of `load_en` cycles, each carrying one `load_word`. Words go in ascending order of index `g*16+a`: group 0 address 0 first, group 7 address 15 last, 128 words in total. `in_ready` can be 1 only from the cycle after the 128th word of a load. Words may arrive in several bursts; the count continues across gaps.
- R3: A `load_en` cycle discards any result still being computed. `out_valid` stays 0 from the cycle after the first word until a new sample has been accepted after the load completes and its computation has finished.
- R4: A sample is taken at a rising edge where `in_valid` and `in_ready` are both 1. `in_ready` is 1 only when the tables are complete, `load_en` is 0, and the block is idle or in the last bit cycle of the current sample. `load_en` has priority over a sample.
- R5: `out_valid` is a one-cycle pulse. It is high in the cycle after the 16th rising edge following the edge that accepted the sample.
- R6: With tables built as described above, `out_data` equals the sum over taps of `c[t]*x[t]`. Here `x[0]` is the sample just accepted and `x[t]` is the sample accepted `t` acceptances earlier. The result is a two's-complement number, 37 bits wide.
- R7: The sample history shifts only when a sample is accepted. Reset clears it to zero. A table load leaves it unchanged.
- R8: If `in_valid` is held high, samples are accepted back to back, one every 16 clocks, and one result is produced per sample.
- R9: `out_data` keeps its value between `out_valid` pulses.
- R10: Samples and table words are two's complement. The sign bit of the sample is weighted by -2^15, so full-scale negative samples with full-scale negative coefficients give +2^35.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Sample offered |
| in_data | input | 16 | Two's-complement sample |
| in_ready | output | 1 | Sample can be taken at this edge |
| load_en | input | 1 | Shift one table word into the table chain |
| load_word | input | 18 | Two's-complement table word |
| out_valid | output | 1 | One-cycle result pulse |
| out_data | output | 37 | Filter result, two's complement |

## Verification
The bench builds the block with its default parameters: 16-bit samples, 32 taps in 8 groups of 4, 18-bit table words, and a 37-bit result. At this size the full 128-word load order, the 16-clock bit loop, and the sign-bit subtraction are all exercised. Full-scale negative samples against full-scale negative coefficients reach the top of the accumulator range. A load split into two bursts, a load that interrupts a computation, and a sample offered during a load check that loads take priority. Several sample streams check that the history survives across loads.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  // Sequencer state: waiting for a sample, or walking its bit positions.
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } da_state_e;

endpackage

// File: rtl/da_fir_ctrl.sv
module da_fir_ctrl
  import da_fir_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int LOAD_N = 128,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(LOAD_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             load_en,
  output logic             in_ready,
  output logic             accept,
  output logic             step,
  output logic             finish,
  output logic             tbl_ok,
  output logic [BIT_W-1:0] bit_idx,
  output logic             bit_last
);

  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LOAD_N - 1);

  da_state_e        state_q, state_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ok_q, ok_d;
  logic             state_en, bit_en, cnt_en;

  // Handshake and phase decode (R4)
  always_comb begin
    bit_last = (bit_q == LAST_BIT);
    in_ready = ok_q && !load_en && ((state_q == ST_IDLE) || bit_last);
    accept   = in_valid && in_ready;
    step     = (state_q == ST_RUN) && !load_en;
    finish   = step && bit_last;
  end

  // Next state
  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    cnt_d    = cnt_q;
    ok_d     = ok_q;
    state_en = 1'b0;
    bit_en   = 1'b0;
    cnt_en   = 1'b0;
    if (load_en) begin
      // A load word aborts any computation (R3) and advances the word count (R2).
      state_d  = ST_IDLE;
      state_en = 1'b1;
      cnt_en   = 1'b1;
      if (cnt_q == LAST_CNT) begin
        cnt_d = '0;
        ok_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
        ok_d  = 1'b0;
      end
    end else if (accept) begin
      state_d  = ST_RUN;
      state_en = 1'b1;
      bit_d    = '0;
      bit_en   = 1'b1;
    end else if (state_q == ST_RUN) begin
      if (bit_last) begin
        state_d  = ST_IDLE;
        state_en = 1'b1;
      end else begin
        bit_d  = bit_q + 1'b1;
        bit_en = 1'b1;
      end
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      cnt_q   <= '0;
      ok_q    <= 1'b0;
    end else begin
      if (state_en) state_q <= state_d;
      if (bit_en)   bit_q   <= bit_d;
      if (cnt_en) begin
        cnt_q <= cnt_d;
        ok_q  <= ok_d;
      end
    end
  end

  assign tbl_ok  = ok_q;
  assign bit_idx = bit_q;

endmodule

// File: rtl/da_fir_taps.sv
module da_fir_taps #(
  parameter  int DATA_W = 16,
  parameter  int TAPS   = 32,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BIT_W-1:0]  bit_idx,
  output logic [TAPS-1:0]   slice
);

  logic [DATA_W-1:0] hist_q [TAPS];

  // Sample history: moves only on acceptance (R7); bit slice picked by index.
  for (genvar t = 0; t < TAPS; t++) begin : g_tap
    if (t == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q[t] <= '0;
        else if (shift_en) hist_q[t] <= in_data;
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_q[t] <= '0;
        else if (shift_en) hist_q[t] <= hist_q[t-1];
      end
    end
    assign slice[t] = hist_q[t][bit_idx];
  end

endmodule

// File: rtl/da_fir_lut_bank.sv
module da_fir_lut_bank #(
  parameter  int NGRP    = 8,
  parameter  int GRP     = 4,
  parameter  int LUT_W   = 18,
  localparam int DEPTH   = 1 << GRP,
  localparam int ENTRIES = NGRP * DEPTH,
  localparam int MEM_AW  = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_en,
  input  logic [LUT_W-1:0]      load_word,
  input  logic [NGRP*GRP-1:0]   slice,
  output logic [NGRP*LUT_W-1:0] lut_out
);

  logic [LUT_W-1:0] mem_q [ENTRIES];

  // Word-serial chain: new word enters at the top index, all others move
  // down one place, so the first word of a full load lands at index 0 (R2).
  for (genvar e = 0; e < ENTRIES; e++) begin : g_cell
    if (e == ENTRIES - 1) begin : g_top
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[e] <= '0;
        else if (load_en) mem_q[e] <= load_word;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mem_q[e] <= '0;
        else if (load_en) mem_q[e] <= mem_q[e+1];
      end
    end
  end

  // One table read per group, addressed by that group's bit slice.
  for (genvar g = 0; g < NGRP; g++) begin : g_rd
    logic [GRP-1:0]    addr;
    logic [MEM_AW-1:0] idx;
    assign addr = slice[g*GRP +: GRP];
    assign idx  = MEM_AW'(g * DEPTH) + MEM_AW'(addr);
    assign lut_out[g*LUT_W +: LUT_W] = mem_q[idx];
  end

endmodule

// File: rtl/da_fir_mac.sv
module da_fir_mac #(
  parameter  int NGRP   = 8,
  parameter  int LUT_W  = 18,
  parameter  int DATA_W = 16,
  localparam int PS_W   = LUT_W + $clog2(NGRP),
  localparam int ACC_W  = PS_W + DATA_W,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int NODES  = 2 * NGRP - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NGRP*LUT_W-1:0]   lut_out,
  input  logic [BIT_W-1:0]        bit_idx,
  input  logic                    bit_last,
  input  logic                    step,
  input  logic                    finish,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);

  logic signed [PS_W-1:0]  node [NODES];
  logic signed [ACC_W-1:0] ps_ext, weighted, term, base, acc_d;
  logic signed [ACC_W-1:0] acc_q, res_q;
  logic                    vld_q;

  // Heap-ordered adder tree: leaves at NGRP-1.., root at node 0.
  for (genvar g = 0; g < NGRP; g++) begin : g_leaf
    assign node[NGRP-1+g] = PS_W'($signed(lut_out[g*LUT_W +: LUT_W]));
  end
  for (genvar i = 0; i < NGRP - 1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  // Shift-and-add; the sign bit position subtracts (R10).
  always_comb begin
    ps_ext   = ACC_W'(node[0]);
    weighted = ps_ext <<< bit_idx;
    term     = bit_last ? -weighted : weighted;
    base     = (bit_idx == '0) ? '0 : acc_q;
    acc_d    = base + term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (step)   acc_q <= acc_d;
      if (finish) res_q <= acc_d;
      vld_q <= finish;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = res_q;

endmodule

// File: rtl/da_fir.sv
module da_fir #(
  parameter  int DATA_W = 16,
  parameter  int TAPS   = 32,
  parameter  int GRP    = 4,
  parameter  int LUT_W  = 18,
  localparam int NGRP   = TAPS / GRP,
  localparam int LOAD_N = NGRP * (1 << GRP),
  localparam int ACC_W  = LUT_W + $clog2(NGRP) + DATA_W,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       in_data,
  output logic                    in_ready,
  input  logic                    load_en,
  input  logic [LUT_W-1:0]        load_word,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_data
);

  logic [1:0]            rst_pipe;
  logic                  rst_int_n;
  logic                  accept, step, finish, tbl_ok, bit_last;
  logic [BIT_W-1:0]      bit_idx;
  logic [TAPS-1:0]       slice;
  logic [NGRP*LUT_W-1:0] lut_out;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  da_fir_ctrl #(
    .DATA_W(DATA_W),
    .LOAD_N(LOAD_N)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .in_valid(in_valid),
    .load_en (load_en),
    .in_ready(in_ready),
    .accept  (accept),
    .step    (step),
    .finish  (finish),
    .tbl_ok  (tbl_ok),
    .bit_idx (bit_idx),
    .bit_last(bit_last)
  );

  da_fir_taps #(
    .DATA_W(DATA_W),
    .TAPS  (TAPS)
  ) u_taps (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .shift_en(accept),
    .in_data (in_data),
    .bit_idx (bit_idx),
    .slice   (slice)
  );

  da_fir_lut_bank #(
    .NGRP (NGRP),
    .GRP  (GRP),
    .LUT_W(LUT_W)
  ) u_lut (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_en  (load_en),
    .load_word(load_word),
    .slice    (slice),
    .lut_out  (lut_out)
  );

  da_fir_mac #(
    .NGRP  (NGRP),
    .LUT_W (LUT_W),
    .DATA_W(DATA_W)
  ) u_mac (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .lut_out  (lut_out),
    .bit_idx  (bit_idx),
    .bit_last (bit_last),
    .step     (step),
    .finish   (finish),
    .out_valid(out_valid),
    .out_data (out_data)
  );

endmodule

// File: rtl/da_fir_chk.sv
module da_fir_chk #(
  parameter int ACC_W = 37
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             load_en,
  input logic             out_valid,
  input logic [ACC_W-1:0] out_data,
  input logic             tbl_ok
);

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R5

  AST_LOAD_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !out_valid); // R3

  AST_NO_RESULT_UNLOADED: assert property (@(posedge clk) disable iff (!rst_n)
    !tbl_ok |-> !out_valid); // R3

  AST_TABLES_BY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tbl_ok) |-> $past(load_en)); // R2

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R4

  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data)); // R9

endmodule

bind da_fir da_fir_chk #(.ACC_W(ACC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .load_en  (load_en),
  .out_valid(out_valid),
  .out_data (out_data),
  .tbl_ok   (tbl_ok)
);

// File: tb/da_fir_tb.sv
module da_fir_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DATA_W = 16;
  localparam int TAPS   = 32;
  localparam int GRP    = 4;
  localparam int LUT_W  = 18;
  localparam int DEPTH  = 16;
  localparam int LOAD_N = 128;
  localparam int ACC_W  = 37;

  logic                    clk;
  logic                    rst_n;
  logic                    in_valid;
  logic [DATA_W-1:0]       in_data;
  logic                    in_ready;
  logic                    load_en;
  logic [LUT_W-1:0]        load_word;
  logic                    out_valid;
  logic signed [ACC_W-1:0] out_data;

  da_fir u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .load_en  (load_en),
    .load_word(load_word),
    .out_valid(out_valid),
    .out_data (out_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int     vec_cnt = 0;
  int     err_cnt = 0;
  string  cur_req = "R1";
  bit     chk_on  = 1'b0;
  bit     done    = 1'b0;

  // Behavioural reference state
  bit     m_ready = 1'b0;
  bit     m_busy  = 1'b0;
  bit     m_ov    = 1'b0;
  int     m_bit   = 0;
  int     m_cnt   = 0;
  longint m_od    = 0;
  int     m_hist [TAPS];
  int     m_coef [TAPS];
  int     pend_coef [TAPS];
  int     coef_a [TAPS];
  int     coef_b [TAPS];

  function automatic longint conv();
    longint s = 0;
    for (int t = 0; t < TAPS; t++) s += longint'(m_coef[t]) * longint'(m_hist[t]);
    return s;
  endfunction

  // Table word k = group k/16, address k%16: sum of coefficients picked by address bits.
  function automatic int tword(input int cf [TAPS], input int k);
    int g = k / DEPTH;
    int a = k % DEPTH;
    int s = 0;
    for (int j = 0; j < GRP; j++) if (((a >> j) & 1) == 1) s += cf[g*GRP + j];
    return s;
  endfunction

  // Compare every clock, then advance the model to the next edge.
  always @(negedge clk) begin
    #1;
    if (chk_on && !done) begin
      bit exp_rdy;
      bit bad = 1'b0;
      exp_rdy = m_ready && (!m_busy || m_bit == DATA_W-1) && !load_en;
      vec_cnt++;
      if (in_ready !== exp_rdy) begin
        bad = 1'b1;
        $display("FAIL %s R4 in_ready act=%0b exp=%0b t=%0t", cur_req, in_ready, exp_rdy, $time);
      end
      if (out_valid !== m_ov) begin
        bad = 1'b1;
        $display("FAIL %s R5 out_valid act=%0b exp=%0b t=%0t", cur_req, out_valid, m_ov, $time);
      end
      if ((^out_data === 1'bx) || (longint'(out_data) != m_od)) begin
        bad = 1'b1;
        $display("FAIL %s R6 R9 out_data act=%0d exp=%0d t=%0t", cur_req, longint'(out_data), m_od, $time);
      end
      if (bad) err_cnt++;

      m_ov = 1'b0;
      if (load_en) begin
        m_busy = 1'b0;
        if (m_cnt == LOAD_N-1) begin
          m_cnt   = 0;
          m_ready = 1'b1;
          m_coef  = pend_coef;
        end else begin
          m_cnt++;
          m_ready = 1'b0;
        end
      end else begin
        if (m_busy && m_bit == DATA_W-1) begin
          m_ov   = 1'b1;
          m_od   = conv();
          m_busy = 1'b0;
        end else if (m_busy) begin
          m_bit++;
        end
        if (in_valid && exp_rdy) begin
          for (int t = TAPS-1; t > 0; t--) m_hist[t] = m_hist[t-1];
          m_hist[0] = int'($signed(in_data));
          m_busy    = 1'b1;
          m_bit     = 0;
        end
      end
    end
  end

  task automatic load_range(input int cf [TAPS], input int first, input int last);
    pend_coef = cf;
    for (int k = first; k <= last; k++) begin
      int w;
      w = tword(cf, k);
      @(negedge clk);
      load_en   = 1'b1;
      load_word = w[LUT_W-1:0];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic send(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v[DATA_W-1:0];
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
  endtask

  initial begin
    for (int t = 0; t < TAPS; t++) begin
      m_hist[t]    = 0;
      m_coef[t]    = 0;
      pend_coef[t] = 0;
      coef_a[t]    = int'($urandom_range(0, 65535)) - 32768;
      coef_b[t]    = -32768;
    end
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_data   = '0;
    load_en   = 1'b0;
    load_word = '0;
    repeat (3) @(negedge clk);
    chk_on = 1'b1;          // R1: outputs idle while reset is held
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R2: split load; a sample offered in the gap must be refused
    cur_req = "R2";
    load_range(coef_a, 0, 4);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'd123;
    repeat (10) @(negedge clk);
    in_valid = 1'b0;
    load_range(coef_a, 5, LOAD_N-1);
    idle(3);

    // R6 R8: impulse then random stream, back to back
    cur_req = "R6 R8";
    send(1);
    for (int i = 0; i < 40; i++) send(int'($urandom_range(0, 65535)) - 32768);
    idle(20);

    // R10: full-scale negative against full-scale negative coefficients
    cur_req = "R10";
    load_range(coef_b, 0, LOAD_N-1);
    for (int i = 0; i < 34; i++) send(-32768);
    for (int i = 0; i < 3; i++) send(32767);
    send(-1);
    idle(20);

    // R3 R4: load interrupts a running computation; sample offered during load
    cur_req = "R3 R4";
    send(500);
    repeat (5) @(negedge clk);
    in_valid = 1'b1;
    in_data  = 16'd77;
    load_range(coef_a, 0, LOAD_N-1);
    idle(20);

    // R7: history carried across the load
    cur_req = "R7";
    for (int i = 0; i < 5; i++) send(int'($urandom_range(0, 65535)) - 32768);
    idle(20);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      err_cnt++;
      $display("FAIL watchdog %s act=running exp=finished", cur_req);
      summary();
      $finish;
    end
  end

endmodule